// File: doc/BRIEF.md
# Pixel Input Format Front End

This block sits at the entry of a composite video encoder datapath. On each rising edge of the pixel clock it captures three 8-bit input buses and a 3-bit format code, and it delivers one luma sample and two colour-difference samples per pixel. Under an RGB code the three buses hold red, green and blue. These values can be perturbed by a small pseudo-random offset and are then converted by a fixed-point colour matrix. Under a YUV code the buses already carry the colour-difference representation, and the matrix is skipped.

The format code also selects two dither enables. One is the RGB-input dither, which this block applies itself. The other is the luma dither, which a later stage applies; this block decodes it and passes it on. Every flag travels through the pipeline alongside its pixel, so the outputs always describe the pixel they accompany. Both formats take the same number of cycles, so the code can change on any pixel without breaking the stream. All outputs are clamped to bounded, asymmetric ranges: luma runs 0..247, U runs ±102 and V runs ±107.

Top module: `pix_format_front`

## Requirements
- R1: A pixel sampled at rising edge k appears on every output right after edge k+3, under both RGB and YUV codes, including when the code alternates from pixel to pixel.
- R2: Under a YUV code, luma is taken from `chan_a`, U from `chan_c` and V from `chan_b`; U and V are read as two's complement.
- R3: `y_out` never exceeds 247 under any code; under a YUV code a luma input above 247 is output as 247.
- R4: `u_out` and `v_out` are two's complement and stay within −102..+102 and −107..+107; under a YUV code, inputs outside those ranges are clamped to the nearest limit.
- R5: Under an RGB code, with red on `chan_a`, green on `chan_b` and blue on `chan_c` (after any dither), Y=(74R+146G+28B+128)>>8, U=(−34R−68G+102B+128)>>>8 and V=(107R−90G−17B+128)>>>8, each then clamped as in R3 and R4 (>>> is an arithmetic shift that rounds toward minus infinity).
- R6: Codes decode as follows: 000 is RGB with RGB dither on and luma dither off; 001 is RGB with both on; 010 is RGB with RGB dither off and luma dither on; 011 is RGB with both off; 100 is YUV with luma dither on; 101 is YUV with luma dither off. The flags appear on `yuv_mode_out`, `rgb_dither_out` and `luma_dither_out`.
- R7: Codes 110 and 111 act exactly like 001, and they raise `code_reserved_out`; every other code leaves it low.
- R8: When RGB dither is on, each colour channel gets an offset in −2..+1 taken from a free-running LFSR, saturated to 0..255 before the matrix. A constant input therefore produces varying luma, and a white input does not wrap.
- R9: When RGB dither is off, and under every YUV code, the result is exact with no perturbation.
- R10: While `rst` is high at a clock edge, all outputs become zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; data is captured on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fmt_code | input | 3 | Format and dither selection code |
| chan_a | input | 8 | Red (RGB) or luma (YUV) |
| chan_b | input | 8 | Green (RGB) or V (YUV) |
| chan_c | input | 8 | Blue (RGB) or U (YUV) |
| y_out | output | 8 | Luma sample, 0..247 |
| u_out | output | 8 | U sample, two's complement |
| v_out | output | 8 | V sample, two's complement |
| yuv_mode_out | output | 1 | Pixel was taken as YUV |
| rgb_dither_out | output | 1 | RGB dither was applied to this pixel |
| luma_dither_out | output | 1 | Luma dither is requested for this pixel |
| code_reserved_out | output | 1 | Pixel arrived with a reserved code |

## Verification
Assertions check several properties on every cycle. The output range limits must hold. A reserved code must come out with both dither flags set. A YUV pixel must never carry RGB dither. The dither stage must be transparent when disabled and must stay within its offset window when enabled. A YUV luma within range must pass through the bypass unchanged. Reset must clear the outputs. Only the bench scenarios can show the things that depend on matching an input to its output: the exact matrix results, the bus mapping in YUV mode, equal latency when the code alternates from pixel to pixel, the fact that dither really varies over a run of identical pixels, and the absence of wrap-around on saturated white.

// File: rtl/pff_pkg.sv
package pff_pkg;
    localparam int PIX_W = 8;
    localparam int ACC_W = 18;
    localparam int FRAC  = 8;

    typedef logic signed [ACC_W-1:0] acc_t;

    localparam acc_t Y_MAX = 18'sd247;
    localparam acc_t U_LIM = 18'sd102;
    localparam acc_t V_LIM = 18'sd107;
    localparam acc_t ROUND = acc_t'(18'sd1 <<< (FRAC - 1));

    // Fixed-point matrix weights (scaled by 2**FRAC)
    localparam acc_t KY_R = 18'sd74;
    localparam acc_t KY_G = 18'sd146;
    localparam acc_t KY_B = 18'sd28;
    localparam acc_t KU_R = -18'sd34;
    localparam acc_t KU_G = -18'sd68;
    localparam acc_t KU_B = 18'sd102;
    localparam acc_t KV_R = 18'sd107;
    localparam acc_t KV_G = -18'sd90;
    localparam acc_t KV_B = -18'sd17;

    typedef enum logic [2:0] {
        CODE_RGB_RD    = 3'b000,
        CODE_RGB_BOTH  = 3'b001,
        CODE_RGB_LD    = 3'b010,
        CODE_RGB_NONE  = 3'b011,
        CODE_YUV_LD    = 3'b100,
        CODE_YUV_PLAIN = 3'b101,
        CODE_RSV_A     = 3'b110,
        CODE_RSV_B     = 3'b111
    } code_e;

    typedef struct packed {
        logic [PIX_W-1:0] a;
        logic [PIX_W-1:0] b;
        logic [PIX_W-1:0] c;
    } pix_t;

    typedef struct packed {
        logic yuv;
        logic rgb_dith;
        logic luma_dith;
        logic rsvd;
    } mode_t;

    function automatic mode_t decode_mode(input logic [2:0] code);
        mode_t m;
        m = '0;
        case (code_e'(code))
            CODE_RGB_RD:    m.rgb_dith = 1'b1;
            CODE_RGB_BOTH:  begin m.rgb_dith = 1'b1; m.luma_dith = 1'b1; end
            CODE_RGB_LD:    m.luma_dith = 1'b1;
            CODE_RGB_NONE:  m = '0;
            CODE_YUV_LD:    begin m.yuv = 1'b1; m.luma_dith = 1'b1; end
            CODE_YUV_PLAIN: m.yuv = 1'b1;
            default: begin
                m.rgb_dith  = 1'b1;
                m.luma_dith = 1'b1;
                m.rsvd      = 1'b1;
            end
        endcase
        return m;
    endfunction

    function automatic logic [PIX_W-1:0] clamp_luma(input acc_t x);
        if (x[ACC_W-1])  return '0;
        if (x > Y_MAX)   return Y_MAX[PIX_W-1:0];
        return x[PIX_W-1:0];
    endfunction

    function automatic logic [PIX_W-1:0] clamp_sym(input acc_t x, input acc_t lim);
        acc_t nlim;
        nlim = -lim;
        if (x > lim)  return lim[PIX_W-1:0];
        if (x < nlim) return nlim[PIX_W-1:0];
        return x[PIX_W-1:0];
    endfunction
endpackage

// File: rtl/pff_capture.sv
module pff_capture
    import pff_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       fmt_code,
    input  logic [PIX_W-1:0] chan_a,
    input  logic [PIX_W-1:0] chan_b,
    input  logic [PIX_W-1:0] chan_c,
    output pix_t             pix_q,
    output mode_t            mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q  <= '0;
            mode_q <= '0;
        end else begin
            pix_q  <= '{a: chan_a, b: chan_b, c: chan_c};
            mode_q <= decode_mode(fmt_code);
        end
    end

    // Reserved flag follows the top two code bits of the previous cycle
    p_reserved_flag_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (mode_q.rsvd == ($past(fmt_code[2:1]) == 2'b11)));
endmodule

// File: rtl/pff_dither.sv
module pff_dither
    import pff_pkg::*;
#(
    parameter int                LFSR_W    = 16,
    parameter int                DITH_W    = 2,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic  clk,
    input  logic  rst,
    input  pix_t  pix_in,
    input  mode_t mode_in,
    output pix_t  pix_q,
    output mode_t mode_q
);
    localparam int NCH     = 3;
    localparam int SUM_W   = PIX_W + 2;
    localparam int OFS_MIN = -(2 ** (DITH_W - 1));
    localparam int OFS_MAX = (2 ** (DITH_W - 1)) - 1;
    localparam logic signed [SUM_W-1:0] SAT_HI = $signed({2'b00, {PIX_W{1'b1}}});

    logic [LFSR_W-1:0]          lfsr;
    logic                       en;
    logic [NCH-1:0][PIX_W-1:0]  ch_in;
    logic [NCH-1:0][PIX_W-1:0]  ch_dith;
    logic [NCH-1:0][PIX_W-1:0]  ch_q;

    assign en    = mode_in.rgb_dith & ~mode_in.yuv;
    assign ch_in = pix_in;
    assign ch_q  = pix_q;

    // Free-running Galois LFSR; NCH*DITH_W must not exceed LFSR_W
    always_ff @(posedge clk) begin
        if (rst)          lfsr <= LFSR_SEED;
        else if (lfsr[0]) lfsr <= (lfsr >> 1) ^ LFSR_TAPS;
        else              lfsr <= lfsr >> 1;
    end

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic signed [DITH_W-1:0] ofs;
        logic signed [SUM_W-1:0]  sum;
        assign ofs = lfsr[k*DITH_W +: DITH_W];
        assign sum = $signed({2'b00, ch_in[k]})
                   + $signed({{(SUM_W-DITH_W){ofs[DITH_W-1]}}, ofs});
        assign ch_dith[k] = sum[SUM_W-1] ? '0 :
                            (sum > SAT_HI) ? {PIX_W{1'b1}} : sum[PIX_W-1:0];

        p_dither_bounded_r8: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(en)) |->
            ((int'(ch_q[k]) - int'($past(ch_in[k])) >= OFS_MIN) &&
             (int'(ch_q[k]) - int'($past(ch_in[k])) <= OFS_MAX)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q  <= '0;
            mode_q <= '0;
        end else begin
            pix_q  <= en ? pix_t'(ch_dith) : pix_in;
            mode_q <= mode_in;
        end
    end

    p_dither_off_exact_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(en)) |-> (pix_q == $past(pix_in)));
endmodule

// File: rtl/pff_matrix.sv
module pff_matrix
    import pff_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pix_t             pix_in,
    input  mode_t            mode_in,
    output logic [PIX_W-1:0] y_out,
    output logic [PIX_W-1:0] u_out,
    output logic [PIX_W-1:0] v_out,
    output mode_t            mode_o
);
    acc_t  r_ext, g_ext, b_ext, u_raw, v_raw;
    acc_t  acc_y, acc_u, acc_v;
    acc_t  sh_y, sh_u, sh_v;
    mode_t mode_s;

    assign r_ext = $signed({{(ACC_W-PIX_W){1'b0}}, pix_in.a});
    assign g_ext = $signed({{(ACC_W-PIX_W){1'b0}}, pix_in.b});
    assign b_ext = $signed({{(ACC_W-PIX_W){1'b0}}, pix_in.c});
    assign u_raw = $signed({{(ACC_W-PIX_W){pix_in.c[PIX_W-1]}}, pix_in.c});
    assign v_raw = $signed({{(ACC_W-PIX_W){pix_in.b[PIX_W-1]}}, pix_in.b});

    // Stage A: products and sums, or raw samples on the bypass path
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_y  <= '0;
            acc_u  <= '0;
            acc_v  <= '0;
            mode_s <= '0;
        end else begin
            mode_s <= mode_in;
            if (mode_in.yuv) begin
                acc_y <= r_ext;
                acc_u <= u_raw;
                acc_v <= v_raw;
            end else begin
                acc_y <= KY_R * r_ext + KY_G * g_ext + KY_B * b_ext;
                acc_u <= KU_R * r_ext + KU_G * g_ext + KU_B * b_ext;
                acc_v <= KV_R * r_ext + KV_G * g_ext + KV_B * b_ext;
            end
        end
    end

    // Stage B: rounding (matrix path only) and range clamping (all paths)
    assign sh_y = mode_s.yuv ? acc_y : (acc_y + ROUND) >>> FRAC;
    assign sh_u = mode_s.yuv ? acc_u : (acc_u + ROUND) >>> FRAC;
    assign sh_v = mode_s.yuv ? acc_v : (acc_v + ROUND) >>> FRAC;

    always_ff @(posedge clk) begin
        if (rst) begin
            y_out  <= '0;
            u_out  <= '0;
            v_out  <= '0;
            mode_o <= '0;
        end else begin
            y_out  <= clamp_luma(sh_y);
            u_out  <= clamp_sym(sh_u, U_LIM);
            v_out  <= clamp_sym(sh_v, V_LIM);
            mode_o <= mode_s;
        end
    end

    acc_t u_chk, v_chk;
    assign u_chk = acc_t'($signed(u_out));
    assign v_chk = acc_t'($signed(v_out));

    p_y_bound_r3: assert property (@(posedge clk) disable iff (rst)
        y_out <= Y_MAX[PIX_W-1:0]);
    p_u_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (u_chk <= U_LIM) && (u_chk >= -U_LIM));
    p_v_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (v_chk <= V_LIM) && (v_chk >= -V_LIM));
    p_bypass_luma_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && mode_o.yuv &&
         ($past(pix_in.a, 2) <= Y_MAX[PIX_W-1:0])) |->
        (y_out == $past(pix_in.a, 2)));
endmodule

// File: rtl/pix_format_front.sv
module pix_format_front
    import pff_pkg::*;
#(
    parameter int                LFSR_W    = 16,
    parameter int                DITH_W    = 2,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] fmt_code,
    input  logic [7:0] chan_a,
    input  logic [7:0] chan_b,
    input  logic [7:0] chan_c,
    output logic [7:0] y_out,
    output logic [7:0] u_out,
    output logic [7:0] v_out,
    output logic       yuv_mode_out,
    output logic       rgb_dither_out,
    output logic       luma_dither_out,
    output logic       code_reserved_out
);
    pix_t  cap_pix, dth_pix;
    mode_t cap_mode, dth_mode, out_mode;

    pff_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .fmt_code (fmt_code),
        .chan_a   (chan_a),
        .chan_b   (chan_b),
        .chan_c   (chan_c),
        .pix_q    (cap_pix),
        .mode_q   (cap_mode)
    );

    pff_dither #(
        .LFSR_W    (LFSR_W),
        .DITH_W    (DITH_W),
        .LFSR_TAPS (LFSR_TAPS),
        .LFSR_SEED (LFSR_SEED)
    ) u_dither (
        .clk     (clk),
        .rst     (rst),
        .pix_in  (cap_pix),
        .mode_in (cap_mode),
        .pix_q   (dth_pix),
        .mode_q  (dth_mode)
    );

    pff_matrix u_matrix (
        .clk     (clk),
        .rst     (rst),
        .pix_in  (dth_pix),
        .mode_in (dth_mode),
        .y_out   (y_out),
        .u_out   (u_out),
        .v_out   (v_out),
        .mode_o  (out_mode)
    );

    assign yuv_mode_out      = out_mode.yuv;
    assign rgb_dither_out    = out_mode.rgb_dith;
    assign luma_dither_out   = out_mode.luma_dith;
    assign code_reserved_out = out_mode.rsvd;

    p_reserved_as_both_r7: assert property (@(posedge clk) disable iff (rst)
        code_reserved_out |-> (rgb_dither_out && luma_dither_out && !yuv_mode_out));
    p_yuv_no_rgb_dither_r6: assert property (@(posedge clk) disable iff (rst)
        yuv_mode_out |-> (!rgb_dither_out && !code_reserved_out));
    p_reset_clears_r10: assert property (@(posedge clk)
        rst |=> (y_out == 8'd0 && u_out == 8'd0 && v_out == 8'd0 &&
                 !yuv_mode_out && !rgb_dither_out && !luma_dither_out &&
                 !code_reserved_out));
endmodule

// File: tb/test_pix_format_front.sv
module test_pix_format_front;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] fmt_code = 3'b001;
    logic [7:0] chan_a = 8'd0, chan_b = 8'd0, chan_c = 8'd0;
    logic [7:0] y_out, u_out, v_out;
    logic       yuv_mode_out, rgb_dither_out, luma_dither_out, code_reserved_out;

    always #5 clk = ~clk;

    pix_format_front i_pix_format_front (
        .clk               (clk),
        .rst               (rst),
        .fmt_code          (fmt_code),
        .chan_a            (chan_a),
        .chan_b            (chan_b),
        .chan_c            (chan_c),
        .y_out             (y_out),
        .u_out             (u_out),
        .v_out             (v_out),
        .yuv_mode_out      (yuv_mode_out),
        .rgb_dither_out    (rgb_dither_out),
        .luma_dither_out   (luma_dither_out),
        .code_reserved_out (code_reserved_out)
    );

    typedef struct {
        int    due;
        int    y, u, v, tol;
        bit    yuv, rd, ld, rs;
        bit    track;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   nchk = 0, nfail = 0;
    int   trk_min = 1000, trk_max = -1;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int clampi(int x, int lo, int hi);
        return (x < lo) ? lo : (x > hi) ? hi : x;
    endfunction

    function automatic int s8(logic [7:0] x);
        return int'($signed(x));
    endfunction

    function automatic int absi(int x);
        return (x < 0) ? -x : x;
    endfunction

    // Driver: applies one pixel at the falling edge and queues its expected result
    task automatic drive(input logic [2:0] cd, input logic [7:0] ia, ib, ic,
                         input string tag, input bit track = 1'b0);
        exp_t e;
        int   r, g, bl;
        @(negedge clk);
        fmt_code = cd; chan_a = ia; chan_b = ib; chan_c = ic;
        e.due = cyc + 4;      // R1: captured at next edge, valid after 3 more
        e.tag = tag; e.track = track;
        e.yuv = 0; e.rd = 0; e.ld = 0; e.rs = 0;
        case (cd)             // R6 / R7 decode table
            3'b000: e.rd = 1;
            3'b001: begin e.rd = 1; e.ld = 1; end
            3'b010: e.ld = 1;
            3'b011: ;
            3'b100: begin e.yuv = 1; e.ld = 1; end
            3'b101: e.yuv = 1;
            default: begin e.rd = 1; e.ld = 1; e.rs = 1; end
        endcase
        if (e.yuv) begin      // R2 mapping, R3/R4 clamps
            e.y = clampi(int'(ia), 0, 247);
            e.u = clampi(s8(ic), -102, 102);
            e.v = clampi(s8(ib), -107, 107);
            e.tol = 0;
        end else begin        // R5 matrix
            r = int'(ia); g = int'(ib); bl = int'(ic);
            e.y = clampi((74*r + 146*g + 28*bl + 128) >>> 8, 0, 247);
            e.u = clampi((-34*r - 68*g + 102*bl + 128) >>> 8, -102, 102);
            e.v = clampi((107*r - 90*g - 17*bl + 128) >>> 8, -107, 107);
            e.tol = e.rd ? 3 : 0;   // R8 dither window, R9 exact otherwise
        end
        q.push_back(e);
    endtask

    // Monitor: compares outputs against queued items when they fall due
    always @(negedge clk) begin
        exp_t e;
        int ay, au, av;
        bit bad;
        #1;
        while (q.size() > 0 && q[0].due == cyc) begin
            e  = q.pop_front();
            ay = int'(y_out); au = s8(u_out); av = s8(v_out);
            bad = (absi(ay - e.y) > e.tol) || (absi(au - e.u) > e.tol) ||
                  (absi(av - e.v) > e.tol) ||
                  (yuv_mode_out != e.yuv) || (rgb_dither_out != e.rd) ||
                  (luma_dither_out != e.ld) || (code_reserved_out != e.rs);
            nchk++;
            if (bad) begin
                nfail++;
                $display("FAIL %s: actual y=%0d u=%0d v=%0d flags=%b%b%b%b expected y=%0d u=%0d v=%0d flags=%b%b%b%b tol=%0d",
                         e.tag, ay, au, av, yuv_mode_out, rgb_dither_out,
                         luma_dither_out, code_reserved_out, e.y, e.u, e.v,
                         e.yuv, e.rd, e.ld, e.rs, e.tol);
            end
            if (e.track) begin
                if (ay < trk_min) trk_min = ay;
                if (ay > trk_max) trk_max = ay;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL R1 watchdog: actual pending=%0d expected pending=0", q.size());
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        // R10: reset with busy inputs
        chan_a = 8'd200; chan_b = 8'd100; chan_c = 8'd50; fmt_code = 3'b111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        nchk++;
        if ({y_out, u_out, v_out} != 24'd0 ||
            {yuv_mode_out, rgb_dither_out, luma_dither_out, code_reserved_out} != 4'd0) begin
            nfail++;
            $display("FAIL R10 reset: actual y=%0d u=%0d v=%0d flags=%b%b%b%b expected all 0",
                     y_out, u_out, v_out, yuv_mode_out, rgb_dither_out,
                     luma_dither_out, code_reserved_out);
        end
        rst = 1'b0;

        // R5 / R9: exact matrix, primaries and sweep, no dither
        drive(3'b011, 8'd255, 8'd255, 8'd255, "R5 white");
        drive(3'b011, 8'd0,   8'd0,   8'd0,   "R5 black");
        drive(3'b011, 8'd255, 8'd0,   8'd0,   "R5 red");
        drive(3'b011, 8'd0,   8'd255, 8'd0,   "R5 green");
        drive(3'b011, 8'd0,   8'd0,   8'd255, "R5 blue");
        drive(3'b011, 8'd255, 8'd255, 8'd0,   "R5 yellow");
        for (int i = 0; i < 24; i++)
            drive(3'b011, 8'(i*37 + 5), 8'(i*91 + 11), 8'(255 - i*13), "R5 R9 sweep");
        drive(3'b010, 8'd10, 8'd200, 8'd90, "R6 R9 code010");

        // R2 / R3 / R4: YUV bypass mapping and clamps
        drive(3'b100, 8'd120, 8'd40,  8'hE0, "R2 yuv map");
        drive(3'b101, 8'd16,  8'hB0,  8'd60, "R2 yuv map plain");
        drive(3'b100, 8'd255, 8'd127, 8'h80, "R3 R4 yuv clamp hi");
        drive(3'b101, 8'd248, 8'h80,  8'd127, "R3 R4 yuv clamp lo");
        drive(3'b100, 8'd247, 8'd107, 8'h9A, "R3 R4 yuv at limits");

        // R1: alternate code every pixel
        for (int i = 0; i < 12; i++) begin
            if (i % 2 == 0) drive(3'b011, 8'(i*20), 8'(200 - i*9), 8'(i*17), "R1 alt rgb");
            else            drive(3'b101, 8'(i*20), 8'(i*7),       8'(250 - i*3), "R1 alt yuv");
        end

        // R6 / R7: dither codes and reserved codes
        drive(3'b000, 8'd100, 8'd150, 8'd200, "R6 code000");
        drive(3'b001, 8'd30,  8'd60,  8'd90,  "R6 code001");
        drive(3'b110, 8'd30,  8'd60,  8'd90,  "R7 code110");
        drive(3'b111, 8'd200, 8'd10,  8'd70,  "R7 code111");

        // R8: saturation on white and on black, and variation over a flat field
        for (int i = 0; i < 6; i++) drive(3'b001, 8'd255, 8'd255, 8'd255, "R8 white sat");
        for (int i = 0; i < 6; i++) drive(3'b000, 8'd0, 8'd0, 8'd0, "R8 black sat");
        for (int i = 0; i < 40; i++) drive(3'b000, 8'd128, 8'd128, 8'd128, "R8 flat gray", 1'b1);

        repeat (8) @(negedge clk);
        #2;
        nchk++;
        if (q.size() != 0) begin
            nfail++;
            $display("FAIL R1 drain: actual pending=%0d expected 0", q.size());
        end
        nchk++;
        if (trk_max <= trk_min) begin
            nfail++;
            $display("FAIL R8 variation: actual spread=%0d expected >0", trk_max - trk_min);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule